// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading two levels of translation entries from memory. A client presents the virtual address and a read/write flag together with the base of the top-level directory. The walker reads one word from the directory, and if that entry is valid, reads one word from the second-level table it points to. It then hands back either a physical address with the leaf's attribute bits, or a fault code with the virtual address and access direction that caused it.

Memory is reached through a small read port. A request channel carries the word address under a valid/ready handshake. A response channel returns the data word with a one-cycle valid and an error flag. Only one walk is active at a time. The end of every walk is marked by a single-cycle `done` pulse, and the result ports then hold their values until the next request is taken.

Top module: `pt_walker`

## Requirements
- R1: After reset, `reqReady` is 1, `done` is 0, `memReqValid` is 0 and `faultCode` is 0.
- R2: The first memory read of a walk is at the directory base plus virtual address bits 31:22 multiplied by 4. The directory base is the `dirBase` value sampled when the request is accepted.
- R3: The second read is at the directory entry with only bit 0 cleared, plus virtual address bits 21:12 multiplied by 4.
- R4: An entry whose bit 0 is 0 ends the walk with `faultCode` = 1 (absent). An absent directory entry causes no second read.
- R5: A successful walk gives `resPaddr` = {leaf bits 31:12, virtual address bits 11:0}, `resAttr` = leaf bits 8:3 and `faultCode` = 0. The attribute bits have no effect on the outcome.
- R6: A read needs leaf bit 1 set and a write needs leaf bit 2 set. If the needed bit is clear, the walk ends with `faultCode` = 3 (denied).
- R7: An error response on either read ends the walk at once with `faultCode` = 2. On any fault, `resPaddr` and `resAttr` are 0.
- R8: `resVaddr` and `resWrite` report the virtual address and direction of the walk that just finished, whether it faulted or not.
- R9: `done` is high for exactly one cycle per walk. `reqReady` is low from acceptance until after `done`, and `reqValid` during that time is ignored.
- R10: Once `memReqValid` is raised, it stays high and `memReqAddr` stays unchanged until `memReqReady` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirBase | input | 32 | Byte address of the top-level directory |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 32 | Byte address of the entry word to read |
| memRspValid | input | 1 | Read data valid (one cycle) |
| memRspData | input | 32 | Read data word |
| memRspErr | input | 1 | Read response is an error |
| done | output | 1 | One-cycle pulse when the result is ready |
| faultCode | output | 2 | 0 ok, 1 absent, 2 bus error, 3 denied |
| resPaddr | output | 32 | Translated physical address (0 on fault) |
| resAttr | output | 6 | Leaf attribute bits 8:3 (0 on fault) |
| resVaddr | output | 32 | Virtual address of the finished walk |
| resWrite | output | 1 | Direction of the finished walk |

## Verification
A corrupted address register or an index taken from the wrong bit field shows up on `memReqAddr` in the first or second request cycle of the walk. This happens well before any result appears. A sequencer stuck in a wrong state shows up as either a missing or doubled `done`, an extra read after an absent directory entry, or `reqReady` rising while a read is still pending. Each of these is visible within a few cycles of the response that triggered it. Faults in the decoding of the present, read and write bits show up only in `faultCode` and `resPaddr` at the `done` cycle. For that reason, the directed walks use leaf words that differ from one another in exactly those bits.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int VA_W     = 32;
  localparam int IDX_W    = 10;
  localparam int OFF_W    = 12;
  localparam int ENT_SH   = 2;
  localparam int L2_LO    = OFF_W;
  localparam int L1_LO    = OFF_W + IDX_W;
  localparam int PRES_BIT = 0;
  localparam int RD_BIT   = 1;
  localparam int WR_BIT   = 2;
  localparam int ATTR_LO  = 3;
  localparam int ATTR_W   = 6;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_BUSERR = 2'd2,
    FLT_DENIED = 2'd3
  } faultKind_e;

  typedef struct packed {
    logic       capReq;
    logic       capL1;
    logic       capLeaf;
    logic       setFault;
    faultKind_e faultKind;
    logic       selL2;
  } walkStrobe_t;
endpackage

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        memRspErr,
  input  logic        entryPresent,
  input  logic        accessOk,
  output logic        done,
  output walkStrobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1REQ, ST_L1RSP, ST_L2REQ, ST_L2RSP, ST_FIN
  } walkState_e;

  walkState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    done        = 1'b0;
    strobe      = '0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capReq = 1'b1;
          nextState     = ST_L1REQ;
        end
      end
      ST_L1REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_L1RSP;
      end
      ST_L1RSP: begin
        if (memRspValid) begin
          if (memRspErr) begin
            strobe.setFault  = 1'b1;
            strobe.faultKind = FLT_BUSERR;
            nextState        = ST_FIN;
          end else if (!entryPresent) begin
            strobe.setFault  = 1'b1;
            strobe.faultKind = FLT_ABSENT;
            nextState        = ST_FIN;
          end else begin
            strobe.capL1 = 1'b1;
            nextState    = ST_L2REQ;
          end
        end
      end
      ST_L2REQ: begin
        strobe.selL2 = 1'b1;
        memReqValid  = 1'b1;
        if (memReqReady) nextState = ST_L2RSP;
      end
      ST_L2RSP: begin
        strobe.selL2 = 1'b1;
        if (memRspValid) begin
          nextState = ST_FIN;
          if (memRspErr) begin
            strobe.setFault  = 1'b1;
            strobe.faultKind = FLT_BUSERR;
          end else if (!entryPresent) begin
            strobe.setFault  = 1'b1;
            strobe.faultKind = FLT_ABSENT;
          end else if (!accessOk) begin
            strobe.setFault  = 1'b1;
            strobe.faultKind = FLT_DENIED;
          end else begin
            strobe.capLeaf = 1'b1;
          end
        end
      end
      ST_FIN: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R10: a raised request is held until taken
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R4: an absent directory entry ends the walk without a second read
  p_absent_stops_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_L1RSP) && memRspValid && !memRspErr && !entryPresent
      |=> done && !memReqValid);
endmodule

// File: rtl/pt_walk_dp.sv
module pt_walk_dp
  import pt_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   dirBase,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [VA_W-1:0]   memRspData,
  output logic [VA_W-1:0]   memReqAddr,
  output logic              entryPresent,
  output logic              accessOk,
  output logic [1:0]        faultCode,
  output logic [VA_W-1:0]   resPaddr,
  output logic [ATTR_W-1:0] resAttr,
  output logic [VA_W-1:0]   resVaddr,
  output logic              resWrite
);
  localparam int PAD_W = VA_W - IDX_W - ENT_SH;

  logic [VA_W-1:0] vaReg, baseReg, l2Base;
  logic            wrReg;
  faultKind_e      faultReg;
  logic [IDX_W-1:0] idxTop, idxLeaf;
  logic [VA_W-1:0]  offTop, offLeaf;

  assign idxTop  = vaReg[L1_LO +: IDX_W];
  assign idxLeaf = vaReg[L2_LO +: IDX_W];
  assign offTop  = {{PAD_W{1'b0}}, idxTop,  {ENT_SH{1'b0}}};
  assign offLeaf = {{PAD_W{1'b0}}, idxLeaf, {ENT_SH{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      wrReg    <= 1'b0;
      baseReg  <= '0;
      l2Base   <= '0;
      resPaddr <= '0;
      resAttr  <= '0;
      faultReg <= FLT_NONE;
    end else begin
      if (strobe.capReq) begin
        vaReg    <= reqVaddr;
        wrReg    <= reqWrite;
        baseReg  <= dirBase;
        resPaddr <= '0;
        resAttr  <= '0;
        faultReg <= FLT_NONE;
      end
      if (strobe.capL1) begin
        l2Base <= memRspData & ~(VA_W'(1) << PRES_BIT);
      end
      if (strobe.capLeaf) begin
        resPaddr <= {memRspData[VA_W-1:OFF_W], vaReg[OFF_W-1:0]};
        resAttr  <= memRspData[ATTR_LO +: ATTR_W];
      end
      if (strobe.setFault) begin
        faultReg <= strobe.faultKind;
      end
    end
  end

  assign memReqAddr   = strobe.selL2 ? (l2Base + offLeaf) : (baseReg + offTop);
  assign entryPresent = memRspData[PRES_BIT];
  assign accessOk     = wrReg ? memRspData[WR_BIT] : memRspData[RD_BIT];
  assign faultCode    = faultReg;
  assign resVaddr     = vaReg;
  assign resWrite     = wrReg;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   dirBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [VA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [VA_W-1:0]   memRspData,
  input  logic              memRspErr,
  output logic              done,
  output logic [1:0]        faultCode,
  output logic [VA_W-1:0]   resPaddr,
  output logic [ATTR_W-1:0] resAttr,
  output logic [VA_W-1:0]   resVaddr,
  output logic              resWrite
);
  walkStrobe_t strobe;
  logic        entryPresent, accessOk;

  pt_walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspErr(memRspErr),
    .entryPresent(entryPresent), .accessOk(accessOk),
    .done(done), .strobe(strobe)
  );

  pt_walk_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dirBase(dirBase), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .memRspData(memRspData), .memReqAddr(memReqAddr),
    .entryPresent(entryPresent), .accessOk(accessOk),
    .faultCode(faultCode), .resPaddr(resPaddr), .resAttr(resAttr),
    .resVaddr(resVaddr), .resWrite(resWrite)
  );

  // R10: address does not move while the request waits
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  // R9: the completion strobe lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: no memory traffic while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid);

  // R5: page offset passes through unchanged on success
  p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    done && (faultCode == 2'd0) |-> resPaddr[OFF_W-1:0] == resVaddr[OFF_W-1:0]);

  // R7: faulted walks carry no address or attributes
  p_fault_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    done && (faultCode != 2'd0) |-> (resPaddr == '0) && (resAttr == '0));
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dirBase = 32'h0010_0000;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        memReqValid, memReqReady;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        memRspErr;
  logic        done;
  logic [1:0]  faultCode;
  logic [31:0] resPaddr, resVaddr;
  logic [5:0]  resAttr;
  logic        resWrite;

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rstN(rstN), .dirBase(dirBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr),
    .done(done), .faultCode(faultCode), .resPaddr(resPaddr), .resAttr(resAttr),
    .resVaddr(resVaddr), .resWrite(resWrite)
  );

  // memory model
  logic [31:0] memWords [logic [31:0]];
  bit          errWords [logic [31:0]];
  int          readyDelay = 0;
  int          rspDelay   = 0;
  int          stallCnt;
  bit          pend;
  int          pendCnt;
  logic [31:0] pendAddr;
  int          rdCnt;
  logic [31:0] rdLog [64];

  function automatic logic [31:0] rdMem(input logic [31:0] a);
    return memWords.exists(a) ? memWords[a] : 32'h0;
  endfunction

  assign memReqReady = !pend && (stallCnt == 0);

  always @(posedge clk) begin
    if (!rstN) begin
      pend <= 1'b0; pendCnt <= 0; pendAddr <= '0; stallCnt <= 0;
      memRspValid <= 1'b0; memRspData <= '0; memRspErr <= 1'b0; rdCnt <= 0;
    end else begin
      memRspValid <= 1'b0;
      memRspErr   <= 1'b0;
      if (pend) begin
        if (pendCnt == 0) begin
          memRspValid <= 1'b1;
          memRspData  <= rdMem(pendAddr);
          memRspErr   <= errWords.exists(pendAddr);
          pend        <= 1'b0;
        end else pendCnt <= pendCnt - 1;
      end
      if (memReqValid && memReqReady) begin
        pend <= 1'b1; pendCnt <= rspDelay; pendAddr <= memReqAddr;
        rdLog[rdCnt % 64] <= memReqAddr;
        rdCnt <= rdCnt + 1;
        stallCnt <= readyDelay;
      end else if (memReqValid && stallCnt != 0) stallCnt <= stallCnt - 1;
      else if (!memReqValid) stallCnt <= readyDelay;
    end
  end

  // request hold monitor (R10)
  int          stTotal = 0, stBad = 0;
  bit          prevStall = 1'b0;
  logic [31:0] prevAddr = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        stTotal++;
        if (!(memReqValid && memReqAddr == prevAddr)) begin
          stBad++;
          $display("FAIL R10 request dropped or moved: valid=%0b addr=%h expected addr=%h",
                   memReqValid, memReqAddr, prevAddr);
        end
      end
      prevStall = memReqValid && !memReqReady;
      prevAddr  = memReqAddr;
    end
  end

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic refWalk(input logic [31:0] va, input bit wr,
                         output logic [1:0] code, output logic [31:0] pa,
                         output logic [5:0] attr, output int nRd,
                         output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] e1, e2;
    code = 2'd0; pa = '0; attr = '0; a2 = '0;
    a1 = dirBase + {20'h0, va[31:22], 2'b00};
    nRd = 1;
    if (errWords.exists(a1)) begin code = 2'd2; return; end
    e1 = rdMem(a1);
    if (!e1[0]) begin code = 2'd1; return; end
    a2 = {e1[31:1], 1'b0} + {20'h0, va[21:12], 2'b00};
    nRd = 2;
    if (errWords.exists(a2)) begin code = 2'd2; return; end
    e2 = rdMem(a2);
    if (!e2[0]) begin code = 2'd1; return; end
    if (wr ? !e2[2] : !e2[1]) begin code = 2'd3; return; end
    pa = {e2[31:12], va[11:0]};
    attr = e2[8:3];
  endtask

  task automatic runWalk(input logic [31:0] va, input bit wr, input bit poke,
                         input string tag);
    logic [1:0]  eCode;
    logic [31:0] ePa, eA1, eA2;
    logic [5:0]  eAttr;
    int          eRd, startCnt, n;
    refWalk(va, wr, eCode, ePa, eAttr, eRd, eA1, eA2);
    @(negedge clk);
    startCnt = rdCnt;
    reqVaddr = va; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    if (poke) begin
      reqVaddr = ~va; reqWrite = ~wr;
      for (int k = 0; k < 2; k++) begin
        check(reqReady == 1'b0, "R9", {tag, " ready while busy"}, 32'(reqReady), 32'h0);
        @(negedge clk);
      end
    end
    reqValid = 1'b0;
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    check(done == 1'b1, "R9", {tag, " done seen"}, 32'(done), 32'h1);
    check(faultCode == eCode, tag, "faultCode", 32'(faultCode), 32'(eCode));
    check(resPaddr == ePa, tag, "resPaddr", resPaddr, ePa);
    check(resAttr == eAttr, tag, "resAttr", 32'(resAttr), 32'(eAttr));
    check(resVaddr == va, "R8", {tag, " resVaddr"}, resVaddr, va);
    check(resWrite == wr, "R8", {tag, " resWrite"}, 32'(resWrite), 32'(wr));
    check(rdCnt - startCnt == eRd, tag, "read count", 32'(rdCnt - startCnt), 32'(eRd));
    check(rdLog[startCnt % 64] == eA1, "R2", {tag, " first read addr"},
          rdLog[startCnt % 64], eA1);
    if (eRd == 2)
      check(rdLog[(startCnt + 1) % 64] == eA2, "R3", {tag, " second read addr"},
            rdLog[(startCnt + 1) % 64], eA2);
    @(negedge clk);
    check(done == 1'b0, "R9", {tag, " done width"}, 32'(done), 32'h0);
    check(reqReady == 1'b1, "R9", {tag, " ready after done"}, 32'(reqReady), 32'h1);
  endtask

  task automatic t_reset();
    check(reqReady == 1'b1, "R1", "reqReady", 32'(reqReady), 32'h1);
    check(done == 1'b0, "R1", "done", 32'(done), 32'h0);
    check(memReqValid == 1'b0, "R1", "memReqValid", 32'(memReqValid), 32'h0);
    check(faultCode == 2'd0, "R1", "faultCode", 32'(faultCode), 32'h0);
  endtask

  task automatic t_mapped();
    runWalk(32'h0040_3ABC, 1'b0, 1'b0, "R5");
    runWalk(32'hFFC0_1FFF, 1'b1, 1'b0, "R3");
    runWalk(32'h0040_6123, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_absent();
    runWalk(32'h0080_0000, 1'b0, 1'b0, "R4");
    runWalk(32'h0040_5000, 1'b1, 1'b0, "R4");
  endtask

  task automatic t_perm();
    runWalk(32'h0040_3004, 1'b1, 1'b0, "R6");
    runWalk(32'h0040_6FF0, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_buserr();
    runWalk(32'h0100_0000, 1'b0, 1'b0, "R7");
    runWalk(32'h0040_7800, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_stall();
    readyDelay = 3; rspDelay = 2;
    runWalk(32'h0040_3ABC, 1'b0, 1'b0, "R10");
    runWalk(32'hFFC0_1234, 1'b1, 1'b0, "R10");
    readyDelay = 0; rspDelay = 0;
  endtask

  task automatic t_busy();
    runWalk(32'hFFC0_1FFF, 1'b1, 1'b1, "R9");
  endtask

  initial begin
    memWords[32'h0010_0004] = 32'h0020_0001;
    memWords[32'h0020_000C] = 32'h8765_4000 | (32'h2D << 3) | 32'h3;
    memWords[32'h0010_0FFC] = 32'h0030_0E07;
    memWords[32'h0030_0E0A] = 32'h1234_5FFF;
    memWords[32'h0020_0018] = 32'hAAAA_A005;
    memWords[32'h0010_0010] = 32'h0050_0001;
    errWords[32'h0010_0010] = 1'b1;
    errWords[32'h0020_001C] = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapped();
    t_absent();
    t_perm();
    t_buserr();
    t_stall();
    t_busy();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total + stTotal, bad + stBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total + stTotal + 1, bad + stBad + 1);
    $finish;
  end
endmodule